// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a small 32-bit CPU. It has sixteen architectural registers. The lower eight exist twice, in two physical banks. The upper eight are single registers that every mode shares. Together that makes 24 physical registers.

A privilege input and a bank-select input choose which bank of the lower eight answers to the ordinary register numbers 0–7. In user mode bank 0 is always the one used, whatever the bank-select bit says. In privileged mode the bank-select bit picks the bank. The bank that is not selected can still be reached through a separate alternate-bank port, which move-to/from-control-register operations use. That port only works in privileged mode. In user mode an access on it is refused and flagged.

The block has two combinational read ports, one write port, a dedicated output that always carries the current register 0 (used as the index register for indexed addressing), and the alternate-bank read/write port. A change of mode or bank-select applies to accesses in the same cycle, and the contents of both banks are kept across the change.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 24 physical registers to zero. After reset, every general read, the index output and every alternate read return 0.
- R2: In user mode (`priv_mode`=0), general reads and writes of registers 0–7 use bank 0, whatever the value of `bank_sel`.
- R3: In privileged mode with `bank_sel`=1, general accesses to registers 0–7 use bank 1, and the alternate port reaches bank 0.
- R4: In privileged mode with `bank_sel`=0, general accesses to registers 0–7 use bank 0, and the alternate port reaches bank 1.
- R5: Registers 8–15 are one shared set. A value written in any mode or bank setting is read back unchanged in every other setting.
- R6: `idx_data` always equals the value that a general read of register 0 would return in the present cycle.
- R7: Writes take effect at the rising clock edge. A general or alternate read of the physical register being written in the same cycle returns the new data, through a bypass.
- R8: An alternate access (`alt_en`=1) in user mode is not performed. No register changes, and `alt_rdata` reads 0 in that cycle. `alt_illegal` is 1 in the following cycle only, unless another such access follows.
- R9: In privileged mode a general write and an alternate write in the same cycle always land in different physical registers, and both take effect.
- R10: A change of `priv_mode` or `bank_sel` steers accesses in the same cycle it is presented, and the contents of both banks are kept across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| bank_sel | input | 1 | Bank used for registers 0–7 in privileged mode |
| rd_a_addr | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_addr | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| idx_data | output | 32 | Current register 0, for indexed addressing |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write register number |
| wr_data | input | 32 | General write data |
| alt_en | input | 1 | Alternate-bank access request |
| alt_we | input | 1 | Alternate access is a write (when `alt_en`=1) |
| alt_addr | input | 3 | Register number 0–7 in the unselected bank |
| alt_wdata | input | 32 | Alternate write data |
| alt_rdata | output | 32 | Alternate read data, 0 when the access is refused |
| alt_illegal | output | 1 | Registered flag for a refused user-mode alternate access |

## Verification
A steering fault, such as a wrong bank for a mode or an alternate path that lands on the selected bank, is not visible in the cycle it happens. It shows only at a later read of the affected register, under the opposite bank setting. The stimulus therefore always reads back each value with the bank setting flipped, through both the general and the alternate path. A fault in the bypass or in the index output shows at once in the same cycle as the write. A missing or stuck refusal flag shows one cycle after the user-mode access.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

  // Bank identifiers for the duplicated low registers
  typedef enum logic {
    BANK_ZERO = 1'b0,
    BANK_ONE  = 1'b1
  } rf_bank_e;

  // Processor privilege level as seen by the register file
  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRIV = 1'b1
  } rf_mode_e;

endpackage

// File: rtl/rf_bank_steer.sv
// Maps architectural register numbers to physical slots.
// Layout: slots [0, NB) bank 0, [NB, 2NB) bank 1, [2NB, 2NB+NS) shared.
module rf_bank_steer
  import rf_bank_pkg::*;
#(
  parameter int NB    = 8,
  parameter int NS    = 8,
  parameter int NGEN  = 4,
  parameter int AW    = $clog2(NB + NS),
  parameter int BAW   = $clog2(NB),
  parameter int PW    = $clog2(2 * NB + NS)
) (
  input  rf_mode_e         mode,
  input  logic             bank_sel,
  input  logic [AW-1:0]    gen_addr [NGEN],
  input  logic [BAW-1:0]   alt_addr,
  output logic [PW-1:0]    gen_phys [NGEN],
  output logic [PW-1:0]    alt_phys,
  output rf_bank_e         active_bank
);

  function automatic logic [PW-1:0] map_general(input logic [AW-1:0] a,
                                                input rf_bank_e b);
    if (a < AW'(NB))
      return PW'(a) + ((b == BANK_ONE) ? PW'(NB) : PW'(0));
    else
      return PW'(a) + PW'(NB);
  endfunction

  always_comb begin
    if (mode == MODE_PRIV && bank_sel)
      active_bank = BANK_ONE;
    else
      active_bank = BANK_ZERO;
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_port
    assign gen_phys[g] = map_general(gen_addr[g], active_bank);
  end

  // The alternate path always reaches the bank not currently selected
  assign alt_phys = PW'(alt_addr) + ((active_bank == BANK_ONE) ? PW'(0) : PW'(NB));

endmodule

// File: rtl/rf_bank_store.sv
// Physical register storage: two write paths, NRD bypassed read ports.
module rf_bank_store #(
  parameter int DW   = 32,
  parameter int NREG = 24,
  parameter int NRD  = 4,
  parameter int PW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            w0_en,
  input  logic [PW-1:0]   w0_idx,
  input  logic [DW-1:0]   w0_data,
  input  logic            w1_en,
  input  logic [PW-1:0]   w1_idx,
  input  logic [DW-1:0]   w1_data,
  input  logic [PW-1:0]   rd_idx  [NRD],
  output logic [DW-1:0]   rd_data [NRD]
);

  logic [DW-1:0] mem [NREG];
  logic          w1_live;

  // The primary path wins if both name the same slot
  assign w1_live = w1_en && !(w0_en && (w0_idx == w1_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (w1_live) mem[w1_idx] <= w1_data;
      if (w0_en)   mem[w0_idx] <= w0_data;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      if (w0_en && (w0_idx == rd_idx[r]))
        rd_data[r] = w0_data;
      else if (w1_live && (w1_idx == rd_idx[r]))
        rd_data[r] = w1_data;
      else
        rd_data[r] = mem[rd_idx[r]];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mem[0] == '0 && mem[NREG-1] == '0));

  // R7
  primary_land_chk: assert property (@(posedge clk) disable iff (rst)
    w0_en |=> mem[$past(w0_idx)] == $past(w0_data));

  // R9
  alt_land_chk: assert property (@(posedge clk) disable iff (rst)
    (w1_en && !(w0_en && w0_idx == w1_idx)) |=> mem[$past(w1_idx)] == $past(w1_data));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_BANKED = 8,
  parameter int NUM_SHARED = 8,
  localparam int AW   = $clog2(NUM_BANKED + NUM_SHARED),
  localparam int BAW  = $clog2(NUM_BANKED),
  localparam int NREG = 2 * NUM_BANKED + NUM_SHARED,
  localparam int PW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_mode,
  input  logic              bank_sel,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] idx_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alt_en,
  input  logic              alt_we,
  input  logic [BAW-1:0]    alt_addr,
  input  logic [DATA_W-1:0] alt_wdata,
  output logic [DATA_W-1:0] alt_rdata,
  output logic              alt_illegal
);

  // General lookup slots: read A, read B, write, index register
  localparam int NGEN = 4;
  localparam int SLOT_RA = 0;
  localparam int SLOT_RB = 1;
  localparam int SLOT_WR = 2;
  localparam int SLOT_IX = 3;
  localparam int NRD = 4;

  rf_mode_e         mode;
  rf_bank_e         active_bank;
  logic [AW-1:0]    gen_addr [NGEN];
  logic [PW-1:0]    gen_phys [NGEN];
  logic [PW-1:0]    alt_phys;
  logic [PW-1:0]    rd_idx   [NRD];
  logic [DATA_W-1:0] rd_data [NRD];
  logic             alt_ok;
  logic             alt_refused;

  assign mode = priv_mode ? MODE_PRIV : MODE_USER;

  assign gen_addr[SLOT_RA] = rd_a_addr;
  assign gen_addr[SLOT_RB] = rd_b_addr;
  assign gen_addr[SLOT_WR] = wr_addr;
  assign gen_addr[SLOT_IX] = '0;

  rf_bank_steer #(
    .NB   (NUM_BANKED),
    .NS   (NUM_SHARED),
    .NGEN (NGEN),
    .AW   (AW),
    .BAW  (BAW),
    .PW   (PW)
  ) u_steer (
    .mode        (mode),
    .bank_sel    (bank_sel),
    .gen_addr    (gen_addr),
    .alt_addr    (alt_addr),
    .gen_phys    (gen_phys),
    .alt_phys    (alt_phys),
    .active_bank (active_bank)
  );

  assign alt_ok      = alt_en && (mode == MODE_PRIV);
  assign alt_refused = alt_en && (mode == MODE_USER);

  assign rd_idx[0] = gen_phys[SLOT_RA];
  assign rd_idx[1] = gen_phys[SLOT_RB];
  assign rd_idx[2] = gen_phys[SLOT_IX];
  assign rd_idx[3] = alt_phys;

  rf_bank_store #(
    .DW   (DATA_W),
    .NREG (NREG),
    .NRD  (NRD),
    .PW   (PW)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .w0_en   (wr_en),
    .w0_idx  (gen_phys[SLOT_WR]),
    .w0_data (wr_data),
    .w1_en   (alt_ok && alt_we),
    .w1_idx  (alt_phys),
    .w1_data (alt_wdata),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign idx_data  = rd_data[2];
  assign alt_rdata = alt_ok ? rd_data[3] : '0;

  always_ff @(posedge clk) begin
    if (rst) alt_illegal <= 1'b0;
    else     alt_illegal <= alt_refused;
  end

  // R8
  illegal_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (alt_en && !priv_mode) |=> alt_illegal);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(alt_en && !priv_mode) |=> !alt_illegal);

  // R8
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (alt_en && !priv_mode) |-> alt_rdata == '0);

  // R2
  user_low_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (!priv_mode && wr_en && wr_addr < AW'(NUM_BANKED)) |-> gen_phys[SLOT_WR] < PW'(NUM_BANKED));

  // R3
  alt_opposite_chk: assert property (@(posedge clk) disable iff (rst)
    (alt_ok && wr_addr < AW'(NUM_BANKED)) |->
      ((alt_phys < PW'(NUM_BANKED)) != (gen_phys[SLOT_WR] < PW'(NUM_BANKED))));

endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        priv;
    logic        bsel;
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic        ae;
    logic        awe;
    logic [2:0]  aaddr;
    logic [31:0] awdata;
    logic [3:0]  ra;
    logic [31:0] expa;
    logic [3:0]  rb;
    logic [31:0] expb;
    logic [31:0] expalt;
    logic [31:0] expidx;
  } vec_t;

  // Each step: drive, check combinational outputs, then clock edge commits.
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    // R2 user writes R0 into bank 0 even with bank_sel=1; bypass R7
    '{1'b0,1'b1, 1'b1,4'd0,32'h11, 1'b0,1'b0,3'd0,32'h0, 4'd0,32'h11, 4'd8,32'h0, 32'h0,  32'h11},
    // R3 privileged bank 1 write; alternate sees bank 0
    '{1'b1,1'b1, 1'b1,4'd0,32'h22, 1'b1,1'b0,3'd0,32'h0, 4'd0,32'h22, 4'd8,32'h0, 32'h11, 32'h22},
    // R4 R10 switch to bank 0; alternate sees bank 1
    '{1'b1,1'b0, 1'b0,4'd0,32'h0,  1'b1,1'b0,3'd0,32'h0, 4'd0,32'h11, 4'd8,32'h0, 32'h22, 32'h11},
    // R5 shared write in user mode
    '{1'b0,1'b1, 1'b1,4'd8,32'h88, 1'b0,1'b0,3'd0,32'h0, 4'd0,32'h11, 4'd8,32'h88,32'h0,  32'h11},
    // R3 alternate write to bank 0 R3 with bypass on alternate read
    '{1'b1,1'b1, 1'b0,4'd0,32'h0,  1'b1,1'b1,3'd3,32'h33,4'd3,32'h0,  4'd8,32'h88,32'h33, 32'h22},
    // R9 both write paths in one cycle, different banks
    '{1'b1,1'b0, 1'b1,4'd3,32'h44, 1'b1,1'b1,3'd3,32'h55,4'd3,32'h44, 4'd0,32'h11,32'h55, 32'h11},
    // R10 contents of both banks kept
    '{1'b1,1'b1, 1'b0,4'd0,32'h0,  1'b1,1'b0,3'd3,32'h0, 4'd3,32'h55, 4'd0,32'h22,32'h44, 32'h22}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        priv_mode, bank_sel;
  logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, idx_data, wr_data;
  logic        wr_en, alt_en, alt_we;
  logic [2:0]  alt_addr;
  logic [31:0] alt_wdata, alt_rdata;
  logic        alt_illegal;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .bank_sel(bank_sel),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .idx_data(idx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alt_en(alt_en), .alt_we(alt_we), .alt_addr(alt_addr),
    .alt_wdata(alt_wdata), .alt_rdata(alt_rdata), .alt_illegal(alt_illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    alt_en = 1'b0; alt_we = 1'b0; alt_addr = '0; alt_wdata = '0;
  endtask

  task automatic sweep_zero(input string tag);
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      idle();
      priv_mode = (m != 0);
      bank_sel  = (m == 2);
      alt_en    = 1'b1;
      for (int a = 0; a < 16; a++) begin
        rd_a_addr = 4'(a);
        rd_b_addr = 4'(15 - a);
        alt_addr  = 3'(a);
        #1;
        check(tag, rd_a_data, 32'h0);
        check(tag, rd_b_data, 32'h0);
        check(tag, idx_data, 32'h0);
        check(tag, alt_rdata, 32'h0);
      end
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; priv_mode = 1'b0; bank_sel = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state in every mode
    check("R1 flag after reset", {31'b0, alt_illegal}, 32'h0);
    sweep_zero("R1 reset contents");

    // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      priv_mode = VECS[v].priv;  bank_sel  = VECS[v].bsel;
      wr_en     = VECS[v].we;    wr_addr   = VECS[v].waddr;  wr_data = VECS[v].wdata;
      alt_en    = VECS[v].ae;    alt_we    = VECS[v].awe;
      alt_addr  = VECS[v].aaddr; alt_wdata = VECS[v].awdata;
      rd_a_addr = VECS[v].ra;    rd_b_addr = VECS[v].rb;
      #1;
      check("R2/R3/R4 read A", rd_a_data, VECS[v].expa);
      check("R5 read B", rd_b_data, VECS[v].expb);
      check("R3/R4 alternate read", alt_rdata, VECS[v].expalt);
      check("R6 index output", idx_data, VECS[v].expidx);
    end

    // R5 shared register seen from privileged bank 0
    @(negedge clk);
    idle(); priv_mode = 1'b1; bank_sel = 1'b0; rd_b_addr = 4'd8;
    #1 check("R5 shared in bank 0 setting", rd_b_data, 32'h88);

    // R8 refused user-mode alternate write
    @(negedge clk);
    priv_mode = 1'b0; bank_sel = 1'b1;
    alt_en = 1'b1; alt_we = 1'b1; alt_addr = 3'd3; alt_wdata = 32'h99;
    rd_a_addr = 4'd3;
    #1;
    check("R8 refused read is zero", alt_rdata, 32'h0);
    check("R2 user R3 is bank 0", rd_a_data, 32'h44);
    @(negedge clk);
    check("R8 flag raised", {31'b0, alt_illegal}, 32'h1);
    idle(); priv_mode = 1'b1; bank_sel = 1'b1; rd_a_addr = 4'd3;
    #1 check("R8 bank 1 unchanged", rd_a_data, 32'h55);
    @(negedge clk);
    check("R8 flag one cycle", {31'b0, alt_illegal}, 32'h0);
    bank_sel = 1'b0;
    #1 check("R8 bank 0 unchanged", rd_a_data, 32'h44);

    // R7 write visible only via bypass before the edge, stored after
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd15; wr_data = 32'hABCD; rd_a_addr = 4'd15;
    #1 check("R7 bypass", rd_a_data, 32'hABCD);
    @(negedge clk);
    idle();
    #1 check("R7 stored at edge", rd_a_data, 32'hABCD);

    // R1 reset after use clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sweep_zero("R1 second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule